// File: doc/BRIEF.md
# Dual-Modulus Preset Counter

This block is a 4-bit synchronous up-counter that runs through one of two short, fixed cycles. The mode input selects the cycle. Each cycle finishes by climbing to all-ones and wrapping to zero. Whenever the counter sits at zero, preset logic loads it with a start value on the next edge. That start value depends on the mode, so the cycle is shortened at its start instead of being cut off at its end.

With mode high, the counter steps through 11, 12, 13, 14, 15, 0 and repeats, which is six states. With mode low, it steps through 9 to 15, then 0, and repeats, which is eight states. The counter has two count enables, and counting needs both of them. A carry output marks the top of the count while the carry-side enable is high. An active-low synchronous clear returns the counter to zero. Because of that, the first edge after clear is released loads the preset.

Top module: `dmod_preset_counter`

## Requirements
- R1: When clr_n is 0 at a rising clock edge, the count becomes 0. This holds whatever the other inputs are, and clear overrides both loading and counting.
- R2: With clr_n at 1 and the count at 0, the next edge loads the preset value. The load ignores en_p and en_t.
- R3: The preset value has bit 3 = 1, bit 2 = 0, bit 1 = mode and bit 0 = 1. This gives 11 (4'b1011) with mode = 1 and 9 (4'b1001) with mode = 0.
- R4: With clr_n at 1, a nonzero count and both en_p and en_t at 1, each edge adds one. Count 15 wraps to 0.
- R5: With clr_n at 1 and a nonzero count, if either enable is 0 the count holds its value across the edge.
- R6: carry is 1 exactly when en_t is 1 and the count is 15. It is combinational from the current count and en_t, and it is 0 whenever en_t is 0, whatever en_p is.
- R7: With mode held at 1 and both enables high, the count repeats 11, 12, 13, 14, 15, 0, a cycle of six states.
- R8: With mode held at 0 and both enables high, the count repeats 9 through 15 and then 0, a cycle of eight states.
- R9: A change of mode in the middle of a cycle leaves the counting alone until the count next reaches 0. The load from 0 then uses the new preset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low |
| mode | input | 1 | Cycle select: 1 gives six states, 0 gives eight |
| en_p | input | 1 | Count enable (parallel side) |
| en_t | input | 1 | Count enable that also gates carry |
| count | output | 4 | Counter state |
| carry | output | 1 | High at count 15 while en_t is high |

## Verification
The bench targets the following corner cases:
- Holding the counter at zero with both enables low. A design that gated the load with the enables would stay stuck at zero.
- Dropping only en_t while the count is 15. A carry that ignored en_t would stay high, and a counter that needed only one enable would move.
- Switching mode at count 12. A design that reloaded at once or consulted mode too early would skip states 13 to 15.
- Asserting clear at zero and in mid-count. A load that took priority over clear would show a preset instead of zero.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

  // Next value of an up-counter, wrapping at all-ones.
  function automatic logic [3:0] dmp_incr4(input logic [3:0] v);
    return v + 4'd1;
  endfunction

  // Preset built from a fixed base with one bit copied from mode.
  function automatic logic [3:0] dmp_preset_of(input logic m,
                                               input logic [3:0] base,
                                               input int unsigned mbit);
    logic [3:0] r;
    r = base;
    r[mbit] = m;
    return r;
  endfunction

endpackage

// File: rtl/dmp_preset.sv
module dmp_preset #(
  parameter int unsigned WIDTH    = 4,
  parameter logic [3:0]  BASE     = 4'd9,
  parameter int unsigned MODE_BIT = 1
) (
  input  logic [WIDTH-1:0] count,
  input  logic             mode,
  output logic             load_n,
  output logic [WIDTH-1:0] preset
);
  import dmp_pkg::*;

  logic at_zero;

  assign at_zero = (count == '0);
  assign load_n  = ~at_zero;
  assign preset  = WIDTH'(dmp_preset_of(mode, BASE, MODE_BIT));

endmodule

// File: rtl/dmp_core.sv
module dmp_core #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             rco
);
  import dmp_pkg::*;

  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic do_clear, do_load, do_count;
  logic [WIDTH-1:0] q_next;

  assign do_clear = ~clr_n;
  assign do_load  = clr_n & ~load_n;
  assign do_count = clr_n & load_n & en_p & en_t;

  always_comb begin
    q_next = q;
    if (do_clear)      q_next = '0;
    else if (do_load)  q_next = d;
    else if (do_count) q_next = WIDTH'(dmp_incr4(4'(q)));
  end

  always_ff @(posedge clk) q <= q_next;

  assign rco = en_t & (q == TOP);

  AST_CLEAR_WINS: assert property (@(posedge clk)
    !clr_n |=> (q == '0)); // R1

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t) |=> (q == WIDTH'(dmp_incr4(4'($past(q)))))); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_p && en_t)) |=> $stable(q)); // R5

  AST_CARRY_GATED: assert property (@(posedge clk) disable iff (!clr_n)
    (!en_t |-> !rco) and (rco |-> (q == TOP))); // R6

endmodule

// File: rtl/dmod_preset_counter.sv
module dmod_preset_counter (
  input  logic       clk,
  input  logic       clr_n,
  input  logic       mode,
  input  logic       en_p,
  input  logic       en_t,
  output logic [3:0] count,
  output logic       carry
);
  localparam int unsigned WIDTH    = 4;
  localparam logic [3:0]  BASE     = 4'd9;
  localparam int unsigned MODE_BIT = 1;

  logic             load_n;
  logic [WIDTH-1:0] preset;

  dmp_preset #(.WIDTH(WIDTH), .BASE(BASE), .MODE_BIT(MODE_BIT)) u_preset (
    .count (count),
    .mode  (mode),
    .load_n(load_n),
    .preset(preset)
  );

  dmp_core #(.WIDTH(WIDTH)) u_core (
    .clk   (clk),
    .clr_n (clr_n),
    .load_n(load_n),
    .en_p  (en_p),
    .en_t  (en_t),
    .d     (preset),
    .q     (count),
    .rco   (carry)
  );

  AST_LOAD_FROM_ZERO: assert property (@(posedge clk) disable iff (!clr_n)
    (count == 4'd0) |=> (count == (mode ? 4'd11 : 4'd9) || $past(mode) != mode
                          || count == ($past(mode) ? 4'd11 : 4'd9))); // R2 R3

  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!clr_n)
    (count != 4'd0) |-> (count >= 4'd9)); // R7 R8

endmodule

// File: tb/test_dmod_preset_counter.sv
module test_dmod_preset_counter;

  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       mode = 1'b1;
  logic       en_p = 1'b1;
  logic       en_t = 1'b1;
  logic [3:0] count;
  logic       carry;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit primed = 0;
  int mdl = 0;

  int    q_exp[$];
  string q_tag[$];

  always #4 clk = ~clk;

  dmod_preset_counter i_dmod_preset_counter (
    .clk(clk), .clr_n(clr_n), .mode(mode), .en_p(en_p), .en_t(en_t),
    .count(count), .carry(carry)
  );

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Driver: applies one cycle of inputs, checks carry, queues the count expected after the edge.
  task automatic step(input logic c, input logic m, input logic p, input logic t,
                      input string note);
    int nxt;
    string tag;
    @(negedge clk);
    clr_n = c; mode = m; en_p = p; en_t = t;
    #1;
    if (primed) begin
      total++;
      if (carry !== ((t == 1'b1) && (mdl == 15))) begin
        bad++;
        $display("FAIL R6 carry: actual=%b expected=%b (count=%0d en_t=%b)",
                 carry, (t == 1'b1) && (mdl == 15), mdl, t);
      end
    end
    if (!c) begin
      nxt = 0; tag = "R1";
    end else if (mdl == 0) begin
      nxt = m ? 11 : 9; tag = "R3";
    end else if (p && t) begin
      nxt = (mdl + 1) % 16;
      tag = (nxt == 0) ? "R4" : (m ? "R7" : "R8");
    end else begin
      nxt = mdl; tag = "R5";
    end
    if (note != "") tag = note;
    q_exp.push_back(nxt);
    q_tag.push_back(tag);
    mdl = nxt;
    primed = 1;
  endtask

  // Monitor: pops one expected count per edge and compares.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_exp.size() > 0) begin
        int e;
        string g;
        e = q_exp.pop_front();
        g = q_tag.pop_front();
        total++;
        if (count !== 4'(e)) begin
          bad++;
          $display("FAIL %s count: actual=%0d expected=%0d", g, count, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R1: clear from power-up
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 1'b1, "R1");
    // R7: six-state cycle, two rounds plus
    for (int i = 0; i < 13; i++) step(1'b1, 1'b1, 1'b1, 1'b1, "");
    // walk to 15
    while (mdl != 15) step(1'b1, 1'b1, 1'b1, 1'b1, "");
    // R5 and R6: en_t low at 15 holds, carry low
    step(1'b1, 1'b1, 1'b1, 1'b0, "R5");
    step(1'b1, 1'b1, 1'b0, 1'b0, "R5");
    // R6: en_t high, en_p low at 15 -> carry high, hold
    step(1'b1, 1'b1, 1'b0, 1'b1, "R5");
    step(1'b1, 1'b1, 1'b0, 1'b1, "R5");
    // wrap to 0 (R4)
    step(1'b1, 1'b1, 1'b1, 1'b1, "R4");
    // R2: load at zero with both enables low
    step(1'b1, 1'b1, 1'b0, 1'b0, "R2");
    step(1'b1, 1'b1, 1'b1, 1'b1, "");
    // R9: mode switches at count 12; 13,14,15,0 unchanged, then load 9
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b1, 1'b1, "R9");
    // R8: eight-state cycle
    for (int i = 0; i < 18; i++) step(1'b1, 1'b0, 1'b1, 1'b1, "");
    // R1: clear in mid-count
    while (mdl != 13) step(1'b1, 1'b0, 1'b1, 1'b1, "");
    step(1'b0, 1'b0, 1'b1, 1'b1, "R1");
    // R1: clear at zero wins over load
    step(1'b0, 1'b1, 1'b1, 1'b1, "R1");
    // R3: load 11 after clear release with mode high
    step(1'b1, 1'b1, 1'b1, 1'b1, "R3");
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b1, 1'b1, "");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule